// File: doc/BRIEF.md
# Dual-Rate Peripheral Tick Generator

This block derives single-cycle clock-enable pulses from one oscillator clock. One pulse stream marks the processor machine cycle. Six more streams serve the peripherals: timer 0, timer 1, timer 2, the serial port, the counter array and the watchdog. No clock is gated. Each consumer runs on the oscillator clock and advances only in cycles where its enable is high.

An 8-bit control byte sets the rates and is loaded through a write strobe. Its lowest bit turns on double-speed operation, in which the processor cycle lasts 6 oscillator periods instead of 12. While double speed is on, each peripheral has its own bit. A cleared bit lets that peripheral follow the fast rate, and a set bit holds it at 12 periods. While double speed is off, every stream runs at 12 periods and the peripheral bits do nothing. The reset value of the double-speed bit comes from a configuration pin.

All streams share one phase counter, so a slow pulse always falls on a fast pulse. A newly written byte is visible on the read port at once. It steers the pulse streams only from the next 12-period boundary, so no consumer ever sees a shortened cycle.

Top module: `tick_rate_gen`

## Requirements
- R1: While reset is low, and just after it is released, the read port shows {7'b0, cfg_dbl_i}. The phase counter starts at 0, so the first 6-period tick comes on the 6th rising edge after release and the first 12-period tick on the 12th.
- R2: A cycle with wr_en_i high stores wr_data_i[6:0]. From the next cycle the read port returns them, with bit 7 always read as 0.
- R3: With double speed off (bit 0 = 0), cpu_tick_o pulses once every 12 clocks.
- R4: With double speed off, every bit of per_tick_o equals cpu_tick_o whatever control bits 6..1 hold.
- R5: With double speed on (bit 0 = 1), cpu_tick_o pulses once every 6 clocks.
- R6: With double speed on and a peripheral's bit at 0, that peripheral's tick pulses every 6 clocks, together with cpu_tick_o.
- R7: With double speed on and a peripheral's bit at 1, that peripheral's tick pulses every 12 clocks, on the cpu_tick_o pulses that close a 12-clock period.
- R8: Every tick is one clock wide, and no peripheral tick occurs in a cycle without a cpu_tick_o pulse.
- R9: A write changes the tick rates only after the next 12-period boundary. Every interval between ticks is a whole 6 or 12 clocks and is never shortened.
- R10: Control bit k+1 (k = 0..5) governs per_tick_o[k]. The order is timer 0, timer 1, timer 2, serial port, counter array, watchdog, so bit 6 is the watchdog.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Oscillator clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| cfg_dbl_i | input | 1 | Reset value of the double-speed bit |
| wr_en_i | input | 1 | Write strobe for the control byte |
| wr_data_i | input | 8 | Control byte to write; bit 7 is discarded |
| rd_data_o | output | 8 | Stored control byte, bit 7 read as 0 |
| cpu_tick_o | output | 1 | Machine-cycle enable pulse |
| per_tick_o | output | 6 | Peripheral enables: [0] timer 0, [1] timer 1, [2] timer 2, [3] serial, [4] counter array, [5] watchdog |

## Verification
The bound checker checks several properties on every cycle. Peripheral pulses must fall within processor pulses. All streams must move in lockstep while double speed is off. The spacing between processor pulses must match the active mode, the active rates may change only just after a boundary pulse, and a write must show on the read port one cycle later. Only the bench scenarios can show the exact phase of the first pulses after reset and the per-bit routing of each peripheral stream. They also show that a write in mid-period leaves the pending pulse pattern unchanged, and that all 64 peripheral settings in both global modes, after each reset configuration, give the right spacing.

// File: rtl/tick_rate_pkg.sv
package tick_rate_pkg;

  localparam int unsigned CTL_W    = 8;
  localparam int unsigned PER_N    = 6;
  localparam int unsigned SLOW_DIV = 12;

  typedef struct packed {
    logic             rsvd;
    logic [PER_N-1:0] per_slow;
    logic             dbl;
  } ctl_t;

endpackage

// File: rtl/trg_phase.sv
module trg_phase #(
  parameter int unsigned SLOW_DIV = 12
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic slow_hit_o,
  output logic fast_hit_o
);

  localparam int unsigned CNT_W = $clog2(SLOW_DIV);
  localparam logic [CNT_W-1:0] LAST_PH = CNT_W'(SLOW_DIV - 1);
  localparam logic [CNT_W-1:0] HALF_PH = CNT_W'(SLOW_DIV / 2 - 1);

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] cnt_nxt;

  always_comb begin
    if (cnt_q == LAST_PH) begin
      cnt_nxt = '0;
    end else begin
      cnt_nxt = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nxt;
    end
  end

  always_comb begin
    slow_hit_o = (cnt_q == LAST_PH);
    fast_hit_o = (cnt_q == LAST_PH) || (cnt_q == HALF_PH);
  end

endmodule

// File: rtl/trg_ctl.sv
module trg_ctl
  import tick_rate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cfg_dbl_i,
  input  logic wr_en_i,
  input  ctl_t wr_data_i,
  input  logic bound_i,
  output ctl_t stg_o,
  output ctl_t act_o
);

  ctl_t stg_q, stg_nxt;
  ctl_t act_q, act_nxt;
  ctl_t rst_val;

  always_comb begin
    rst_val          = '0;
    rst_val.dbl      = cfg_dbl_i;
  end

  // Staged copy follows every write; the reserved bit is discarded.
  always_comb begin
    stg_nxt = stg_q;
    if (wr_en_i) begin
      stg_nxt.per_slow = wr_data_i.per_slow;
      stg_nxt.dbl      = wr_data_i.dbl;
      stg_nxt.rsvd     = wr_data_i.rsvd & 1'b0;
    end
  end

  // Active copy moves only at the end of a full slow period.
  always_comb begin
    act_nxt = act_q;
    if (bound_i) begin
      act_nxt = stg_q;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stg_q <= rst_val;
      act_q <= rst_val;
    end else begin
      stg_q <= stg_nxt;
      act_q <= act_nxt;
    end
  end

  assign stg_o = stg_q;
  assign act_o = act_q;

endmodule

// File: rtl/trg_rate_sel.sv
module trg_rate_sel #(
  parameter int unsigned PER_N = 6
) (
  input  logic             dbl_i,
  input  logic [PER_N-1:0] per_slow_i,
  input  logic             slow_hit_i,
  input  logic             fast_hit_i,
  output logic             cpu_tick_o,
  output logic [PER_N-1:0] per_tick_o
);

  always_comb begin
    cpu_tick_o = dbl_i ? fast_hit_i : slow_hit_i;
  end

  for (genvar g = 0; g < PER_N; g++) begin : g_per
    logic use_fast;
    always_comb begin
      use_fast      = dbl_i & ~per_slow_i[g];
      per_tick_o[g] = use_fast ? fast_hit_i : slow_hit_i;
    end
  end

endmodule

// File: rtl/tick_rate_gen.sv
module tick_rate_gen
  import tick_rate_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_dbl_i,
  input  logic             wr_en_i,
  input  logic [CTL_W-1:0] wr_data_i,
  output logic [CTL_W-1:0] rd_data_o,
  output logic             cpu_tick_o,
  output logic [PER_N-1:0] per_tick_o
);

  logic slow_hit;
  logic fast_hit;
  ctl_t stg_q;
  ctl_t act_q;

  trg_phase #(
    .SLOW_DIV (SLOW_DIV)
  ) i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .slow_hit_o (slow_hit),
    .fast_hit_o (fast_hit)
  );

  trg_ctl i_ctl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cfg_dbl_i (cfg_dbl_i),
    .wr_en_i   (wr_en_i),
    .wr_data_i (ctl_t'(wr_data_i)),
    .bound_i   (slow_hit),
    .stg_o     (stg_q),
    .act_o     (act_q)
  );

  trg_rate_sel #(
    .PER_N (PER_N)
  ) i_sel (
    .dbl_i      (act_q.dbl),
    .per_slow_i (act_q.per_slow),
    .slow_hit_i (slow_hit),
    .fast_hit_i (fast_hit),
    .cpu_tick_o (cpu_tick_o),
    .per_tick_o (per_tick_o)
  );

  assign rd_data_o = stg_q;

endmodule

// File: rtl/tick_rate_gen_chk.sv
module tick_rate_gen_chk
  import tick_rate_pkg::*;
(
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wr_en_i,
  input logic [CTL_W-1:0] wr_data_i,
  input logic [CTL_W-1:0] rd_data_o,
  input logic             cpu_tick_o,
  input logic [PER_N-1:0] per_tick_o,
  input logic             act_dbl,
  input logic [PER_N-1:0] act_per
);

  localparam int unsigned GAP_W = $clog2(SLOW_DIV) + 1;
  localparam logic [GAP_W-1:0] GAP_SLOW = GAP_W'(SLOW_DIV - 1);
  localparam logic [GAP_W-1:0] GAP_FAST = GAP_W'(SLOW_DIV / 2 - 1);

  logic [GAP_W-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      gap_q <= '0;
    end else if (cpu_tick_o) begin
      gap_q <= '0;
    end else if (gap_q != '1) begin
      gap_q <= gap_q + 1'b1;
    end
  end

  AST_PER_WITHIN_CPU: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|per_tick_o) |-> cpu_tick_o); // R8

  AST_SLOW_LOCKSTEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !act_dbl |-> (per_tick_o == {PER_N{cpu_tick_o}})); // R4

  AST_SLOW_CPU_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_tick_o && !act_dbl) |-> (gap_q == GAP_SLOW)); // R3

  AST_FAST_CPU_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cpu_tick_o && act_dbl) |-> (gap_q == GAP_FAST)); // R5

  AST_SWITCH_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable({act_dbl, act_per}) |-> $past(cpu_tick_o)); // R9

  AST_WRITE_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> (rd_data_o == {1'b0, $past(wr_data_i[CTL_W-2:0])})); // R2

endmodule

bind tick_rate_gen tick_rate_gen_chk i_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_data_i  (wr_data_i),
  .rd_data_o  (rd_data_o),
  .cpu_tick_o (cpu_tick_o),
  .per_tick_o (per_tick_o),
  .act_dbl    (act_q.dbl),
  .act_per    (act_q.per_slow)
);

// File: tb/test_tick_rate_gen.sv
`timescale 1ns/1ps
module test_tick_rate_gen;

  logic       clk_i = 1'b0;
  logic       rst_ni;
  logic       cfg_dbl_i;
  logic       wr_en_i;
  logic [7:0] wr_data_i;
  logic [7:0] rd_data_o;
  logic       cpu_tick_o;
  logic [5:0] per_tick_o;

  int checks = 0;
  int errors = 0;
  int ncyc   = 0;
  bit done   = 1'b0;
  logic [6:0] ctl_m;
  logic [6:0] act_m;

  always #2 clk_i = ~clk_i;

  tick_rate_gen i_tick_rate_gen (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cfg_dbl_i  (cfg_dbl_i),
    .wr_en_i    (wr_en_i),
    .wr_data_i  (wr_data_i),
    .rd_data_o  (rd_data_o),
    .cpu_tick_o (cpu_tick_o),
    .per_tick_o (per_tick_o)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cyc %0d actual %h expected %h", tag, what, ncyc, act, exp);
    end
  endtask

  // One clock: check outputs at the negedge, model the next edge, drive.
  task automatic tick(input logic wr, input logic [7:0] d, input string tag);
    int ph;
    logic slow, fast, cpu_e;
    logic [5:0] per_e;
    logic [6:0] nxt_act;
    ph    = ncyc % 12;
    slow  = (ph == 11);
    fast  = (ph == 5) || (ph == 11);
    cpu_e = act_m[0] ? fast : slow;
    for (int k = 0; k < 6; k++) per_e[k] = (act_m[0] && !act_m[k+1]) ? fast : slow;
    chk(cpu_tick_o === cpu_e, act_m[0] ? "R5" : "R3", {tag, " cpu_tick"},
        {7'b0, cpu_tick_o}, {7'b0, cpu_e});
    chk(per_tick_o === per_e, !act_m[0] ? "R4" : "R6/R7", {tag, " per_tick"},
        {2'b0, per_tick_o}, {2'b0, per_e});
    chk(!(|(per_tick_o & ~{6{cpu_tick_o}})), "R8", {tag, " per without cpu"},
        {2'b0, per_tick_o}, {7'b0, cpu_tick_o});
    chk(rd_data_o === {1'b0, ctl_m}, "R2", {tag, " readback"}, rd_data_o, {1'b0, ctl_m});
    nxt_act = (ph == 11) ? ctl_m : act_m;
    wr_en_i   = wr;
    wr_data_i = d;
    if (wr) ctl_m = d[6:0];
    act_m = nxt_act;
    @(posedge clk_i);
    ncyc++;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  task automatic run(input int n, input string tag);
    for (int i = 0; i < n; i++) tick(1'b0, 8'h00, tag);
  endtask

  task automatic do_reset(input logic cfg);
    @(negedge clk_i);
    rst_ni = 1'b0;
    cfg_dbl_i = cfg;
    wr_en_i = 1'b0;
    wr_data_i = 8'h00;
    repeat (3) @(negedge clk_i);
    chk(rd_data_o === {7'b0, cfg}, "R1", "readback in reset", rd_data_o, {7'b0, cfg});
    chk(cpu_tick_o === 1'b0 && per_tick_o === 6'b0, "R1", "ticks in reset",
        {1'b0, cpu_tick_o, per_tick_o}, 8'h00);
    rst_ni = 1'b1;
    ncyc = 0;
    ctl_m = {6'b0, cfg};
    act_m = {6'b0, cfg};
  endtask

  // R1: first ticks land at the right phase for each reset configuration
  task automatic t_reset(input logic cfg);
    do_reset(cfg);
    run(30, "R1");
  endtask

  // R2: full-byte write, reserved bit reads as zero
  task automatic t_readback();
    tick(1'b1, 8'hFF, "R2");
    chk(rd_data_o === 8'h7F, "R2", "bit7 masked", rd_data_o, 8'h7F);
    tick(1'b1, 8'h80, "R2");
    chk(rd_data_o === 8'h00, "R2", "only bit7 set", rd_data_o, 8'h00);
    run(26, "R2");
  endtask

  // R3/R4/R6/R7: every peripheral pattern under one global setting
  task automatic t_sweep(input logic glb);
    for (int m = 0; m < 64; m++) begin
      tick(1'b1, {1'b0, 6'(m), glb}, glb ? "R6/R7 sweep" : "R4 sweep");
      run(14 + (m % 5) * 3, glb ? "R6/R7 sweep" : "R4 sweep");
    end
  endtask

  // R10: one slow bit at a time under double speed
  task automatic t_bitmap();
    for (int k = 0; k < 6; k++) begin
      tick(1'b1, 8'(1 + (2 << k)), "R10");
      run(28, "R10");
    end
  endtask

  // R9: mid-period writes wait for the boundary
  task automatic t_midswitch();
    tick(1'b1, 8'h00, "R9");
    run(24, "R9");
    while (ncyc % 12 != 2) tick(1'b0, 8'h00, "R9");
    tick(1'b1, 8'h01, "R9");
    while (ncyc % 12 != 5) tick(1'b0, 8'h00, "R9");
    chk(cpu_tick_o === 1'b0, "R9", "no early fast tick", {7'b0, cpu_tick_o}, 8'h00);
    run(14, "R9");
    while (ncyc % 12 != 7) tick(1'b0, 8'h00, "R9");
    tick(1'b1, 8'h00, "R9");
    run(12, "R9");
    chk(cpu_tick_o === 1'b0, "R9", "slow after boundary", {7'b0, cpu_tick_o}, 8'h00);
    run(12, "R9");
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL R3 watchdog cycles 200000 expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_ni = 1'b0;
    cfg_dbl_i = 1'b0;
    wr_en_i = 1'b0;
    wr_data_i = 8'h00;
    for (int c = 0; c < 2; c++) begin
      t_reset(c[0]);
      t_readback();
      do_reset(c[0]);
      t_sweep(1'b0);
      t_sweep(1'b1);
      t_bitmap();
      t_midswitch();
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule